// File: doc/BRIEF.md
# Interrupt Destination Set Resolver

This block takes one interrupt command at a time and works out which local agents must receive it. From the destination byte, an addressing-mode bit, a two-bit shorthand and the requester's own ID, it builds a one-bit-per-agent selection over the whole ID space. The ID space is 256 entries, held as eight 32-bit words. Only agents whose ID is below the current agent count take part. A small configuration store holds each agent's logical destination byte and its four-bit destination format. Each agent can then be addressed logically in either flat or cluster style.

Once the selection is captured, the block walks it and emits one delivery event per clock, in ascending agent order. Each event carries the agent ID, the delivery mode, the vector, the trigger bit and a flag marking an arbitration-ID synchronisation. For lowest-priority delivery only the lowest-numbered selected agent is served. While a walk is in progress the block reports busy and holds off further commands. The agents themselves are outside the block. They act on the events, for example a start-up event is used only by an agent that is halted.

Top module: `irq_route`

## Requirements
- R1: An agent whose ID is not below `agent_count` never receives an event. ID 255 is never a valid agent.
- R2: Physical addressing (`cmd_logical`=0, shorthand 0): destination 0xFF selects every present agent. Any other value selects only the agent with that ID.
- R3: Logical addressing, agent format 4'hF (flat): the agent is selected when the destination byte AND its logical byte is nonzero.
- R4: Logical addressing, agent format 4'h0 (cluster): the agent is selected when the upper nibbles are equal and the lower nibbles share a set bit. Agents with any other format value are never selected logically.
- R5: Shorthand codes: 0 uses destination and addressing mode, 1 selects only the requester, 2 selects all present agents, 3 selects all present agents except the requester.
- R6: Mode 3'd1 (lowest priority) emits exactly one event, to the lowest-numbered selected agent.
- R7: Modes 3'd0 (fixed), 3'd5 (INIT) and 3'd6 (start-up) emit one event per selected agent, one per clock, in ascending ID order. Each event carries the command's vector, trigger and mode.
- R8: A mode 3'd5 command with `cmd_level`=0 and `cmd_trig`=1 emits its events with `dlv_sync`=1 (copy ID into arbitration ID). All other events have `dlv_sync`=0.
- R9: The command is captured on a clock edge with `cmd_valid` high and `cmd_busy` low. The first event appears after the following edge. `cmd_busy` stays high until the edge that emits the last event. An empty selection or an unsupported mode code (2, 3, 4, 7) leaves `cmd_busy` low and emits nothing.
- R10: After reset every agent has format 4'hF and logical byte 0x00, and `cmd_busy` and `dlv_valid` are low.
- R11: A configuration write on the same edge as a command capture does not affect that command. The command uses the previous contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write enable for the per-agent configuration |
| cfg_agent | input | 8 | Agent ID being configured |
| cfg_logical_id | input | 8 | Logical destination byte to store |
| cfg_format | input | 4 | Destination format to store (F flat, 0 cluster) |
| agent_count | input | 8 | Number of present agents (IDs 0..count-1) |
| cmd_valid | input | 1 | Command request |
| cmd_dest | input | 8 | Destination byte |
| cmd_logical | input | 1 | 1 logical addressing, 0 physical |
| cmd_shorthand | input | 2 | Destination shorthand |
| cmd_mode | input | 3 | Delivery mode code |
| cmd_vector | input | 8 | Interrupt vector |
| cmd_trig | input | 1 | Trigger mode bit |
| cmd_level | input | 1 | Level bit |
| cmd_src | input | 8 | Requester's own ID |
| cmd_busy | output | 1 | Walk in progress, commands held off |
| dlv_valid | output | 1 | Delivery event this cycle |
| dlv_agent | output | 8 | Target agent ID |
| dlv_mode | output | 3 | Delivery mode of the event |
| dlv_vector | output | 8 | Vector of the event |
| dlv_trig | output | 1 | Trigger bit of the event |
| dlv_sync | output | 1 | Arbitration-ID synchronisation event |

## Verification
Two functions can fall on the same edge: a configuration write and a command capture, and a capture on the edge right after a walk emits its last event. The bench drives a logical command together with a write that clears a matching agent's logical byte on the same edge. It expects the old match to be delivered, then repeats the command and expects the agent to drop out. Commands are also issued back to back. The bench's reference model decides each cycle whether the held command is captured and compares busy and every event against its own queue.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
  localparam int FMT_W = 4;

  localparam logic [2:0] MODE_FIXED   = 3'd0;
  localparam logic [2:0] MODE_LOWEST  = 3'd1;
  localparam logic [2:0] MODE_INIT    = 3'd5;
  localparam logic [2:0] MODE_STARTUP = 3'd6;

  localparam logic [FMT_W-1:0] FMT_FLAT    = 4'hF;
  localparam logic [FMT_W-1:0] FMT_CLUSTER = 4'h0;

  localparam logic [1:0] SH_NONE   = 2'd0;
  localparam logic [1:0] SH_SELF   = 2'd1;
  localparam logic [1:0] SH_ALL    = 2'd2;
  localparam logic [1:0] SH_OTHERS = 2'd3;

  function automatic logic mode_known(input logic [2:0] m);
    return (m == MODE_FIXED) || (m == MODE_LOWEST) ||
           (m == MODE_INIT)  || (m == MODE_STARTUP);
  endfunction
endpackage

// File: rtl/irq_route_cfg.sv
module irq_route_cfg
  import irq_route_pkg::*;
#(
  parameter int N_AGENTS = 255,
  parameter int ID_W     = 8
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                we,
  input  logic [ID_W-1:0]                     agent,
  input  logic [ID_W-1:0]                     log_in,
  input  logic [FMT_W-1:0]                    fmt_in,
  output logic [N_AGENTS-1:0][ID_W-1:0]       log_ids,
  output logic [N_AGENTS-1:0][FMT_W-1:0]      fmts
);
  // per-agent write enable decoded from the agent number
  logic [N_AGENTS-1:0] wr_en;

  always_comb begin
    for (int i = 0; i < N_AGENTS; i++) begin
      wr_en[i] = we && (agent == ID_W'(i));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N_AGENTS; i++) begin
        log_ids[i] <= '0;
        fmts[i]    <= FMT_FLAT;
      end
    end else begin
      for (int i = 0; i < N_AGENTS; i++) begin
        if (wr_en[i]) begin
          log_ids[i] <= log_in;
          fmts[i]    <= fmt_in;
        end
      end
    end
  end
endmodule

// File: rtl/irq_route_match.sv
module irq_route_match
  import irq_route_pkg::*;
#(
  parameter int N_AGENTS = 255,
  parameter int ID_W     = 8,
  parameter int MASK_W   = 256
) (
  input  logic [ID_W-1:0]                dest,
  input  logic                           logical,
  input  logic [1:0]                     shorthand,
  input  logic [ID_W-1:0]                src,
  input  logic [ID_W-1:0]                count,
  input  logic [N_AGENTS-1:0][ID_W-1:0]  log_ids,
  input  logic [N_AGENTS-1:0][FMT_W-1:0] fmts,
  output logic [MASK_W-1:0]              sel
);
  localparam int HALF = ID_W / 2;

  for (genvar i = 0; i < MASK_W; i++) begin : g_agent
    if (i < N_AGENTS) begin : g_live
      localparam logic [ID_W-1:0] MY_ID = ID_W'(i);
      logic [ID_W-1:0]  lid;
      logic [FMT_W-1:0] fmt;
      logic phys_hit, flat_hit, clus_hit, addr_hit, pick;

      assign lid = log_ids[i];
      assign fmt = fmts[i];

      always_comb begin
        phys_hit = (dest == '1) || (dest == MY_ID);
        flat_hit = (fmt == FMT_FLAT) && (|(dest & lid));
        clus_hit = (fmt == FMT_CLUSTER) &&
                   (dest[ID_W-1:HALF] == lid[ID_W-1:HALF]) &&
                   (|(dest[HALF-1:0] & lid[HALF-1:0]));
        addr_hit = logical ? (flat_hit | clus_hit) : phys_hit;
        case (shorthand)
          SH_NONE: pick = addr_hit;
          SH_SELF: pick = (src == MY_ID);
          SH_ALL:  pick = 1'b1;
          default: pick = (src != MY_ID);
        endcase
      end

      assign sel[i] = pick && (MY_ID < count);
    end else begin : g_absent
      assign sel[i] = 1'b0;
    end
  end
endmodule

// File: rtl/irq_route_ffs.sv
module irq_route_ffs #(
  parameter int MASK_W = 256,
  parameter int WORD_W = 32,
  parameter int IDX_W  = $clog2(MASK_W)
) (
  input  logic [MASK_W-1:0] vec,
  output logic              found,
  output logic [IDX_W-1:0]  idx
);
  localparam int WORDS  = MASK_W / WORD_W;
  localparam int WBIT_W = $clog2(WORD_W);
  localparam int WSEL_W = $clog2(WORDS);

  logic [WORDS-1:0]  w_hit;
  logic [WBIT_W-1:0] w_pos [WORDS];
  logic [WSEL_W-1:0] sel_w;

  // lowest set bit inside every word
  always_comb begin
    for (int w = 0; w < WORDS; w++) begin
      w_hit[w] = |vec[w*WORD_W +: WORD_W];
      w_pos[w] = '0;
      for (int b = WORD_W - 1; b >= 0; b--) begin
        if (vec[w*WORD_W + b]) w_pos[w] = WBIT_W'(b);
      end
    end
  end

  // lowest word that holds a set bit
  always_comb begin
    found = |w_hit;
    sel_w = '0;
    for (int w = WORDS - 1; w >= 0; w--) begin
      if (w_hit[w]) sel_w = WSEL_W'(w);
    end
    idx = IDX_W'({sel_w, w_pos[sel_w]});
  end
endmodule

// File: rtl/irq_route.sv
module irq_route
  import irq_route_pkg::*;
#(
  parameter int N_AGENTS = 255,
  parameter int ID_W     = 8,
  parameter int WORD_W   = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [ID_W-1:0]  cfg_agent,
  input  logic [ID_W-1:0]  cfg_logical_id,
  input  logic [3:0]       cfg_format,
  input  logic [ID_W-1:0]  agent_count,
  input  logic             cmd_valid,
  input  logic [ID_W-1:0]  cmd_dest,
  input  logic             cmd_logical,
  input  logic [1:0]       cmd_shorthand,
  input  logic [2:0]       cmd_mode,
  input  logic [7:0]       cmd_vector,
  input  logic             cmd_trig,
  input  logic             cmd_level,
  input  logic [ID_W-1:0]  cmd_src,
  output logic             cmd_busy,
  output logic             dlv_valid,
  output logic [ID_W-1:0]  dlv_agent,
  output logic [2:0]       dlv_mode,
  output logic [7:0]       dlv_vector,
  output logic             dlv_trig,
  output logic             dlv_sync
);
  localparam int MASK_W = 1 << ID_W;

  logic [N_AGENTS-1:0][ID_W-1:0]  log_ids;
  logic [N_AGENTS-1:0][FMT_W-1:0] fmts;
  logic [MASK_W-1:0]              sel;

  logic [MASK_W-1:0] mask_q, mask_d, clr_bit;
  logic              pick_found;
  logic [ID_W-1:0]   pick_idx;
  logic              accept;

  logic [2:0]        mode_q;
  logic [7:0]        vec_q;
  logic              trig_q, sync_q, sync_d;
  logic              valid_q, valid_d;
  logic [ID_W-1:0]   agent_q;

  irq_route_cfg #(.N_AGENTS(N_AGENTS), .ID_W(ID_W)) u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (cfg_we),
    .agent   (cfg_agent),
    .log_in  (cfg_logical_id),
    .fmt_in  (cfg_format),
    .log_ids (log_ids),
    .fmts    (fmts)
  );

  irq_route_match #(.N_AGENTS(N_AGENTS), .ID_W(ID_W), .MASK_W(MASK_W)) u_match (
    .dest      (cmd_dest),
    .logical   (cmd_logical),
    .shorthand (cmd_shorthand),
    .src       (cmd_src),
    .count     (agent_count),
    .log_ids   (log_ids),
    .fmts      (fmts),
    .sel       (sel)
  );

  irq_route_ffs #(.MASK_W(MASK_W), .WORD_W(WORD_W), .IDX_W(ID_W)) u_ffs (
    .vec   (mask_q),
    .found (pick_found),
    .idx   (pick_idx)
  );

  assign cmd_busy = |mask_q;
  assign accept   = cmd_valid && !cmd_busy;
  assign clr_bit  = MASK_W'(1) << pick_idx;
  assign sync_d   = (cmd_mode == MODE_INIT) && !cmd_level && cmd_trig;

  // next state of the pending selection and the event register
  always_comb begin
    mask_d  = mask_q;
    valid_d = 1'b0;
    if (accept) begin
      mask_d = mode_known(cmd_mode) ? sel : '0;
    end else if (pick_found) begin
      valid_d = 1'b1;
      mask_d  = (mode_q == MODE_LOWEST) ? '0 : (mask_q & ~clr_bit);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
    end else begin
      mask_q <= mask_d;
    end
  end

  // command fields, loaded on capture
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_FIXED;
      vec_q  <= '0;
      trig_q <= 1'b0;
      sync_q <= 1'b0;
    end else if (accept) begin
      mode_q <= cmd_mode;
      vec_q  <= cmd_vector;
      trig_q <= cmd_trig;
      sync_q <= sync_d;
    end
  end

  // event register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      agent_q <= '0;
    end else begin
      valid_q <= valid_d;
      if (valid_d) agent_q <= pick_idx;
    end
  end

  assign dlv_valid  = valid_q;
  assign dlv_agent  = agent_q;
  assign dlv_mode   = mode_q;
  assign dlv_vector = vec_q;
  assign dlv_trig   = trig_q;
  assign dlv_sync   = sync_q;
endmodule

// File: rtl/irq_route_chk.sv
module irq_route_chk
  import irq_route_pkg::*;
#(
  parameter int N_AGENTS = 255,
  parameter int ID_W     = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cmd_valid,
  input logic [2:0]      cmd_mode,
  input logic            cmd_busy,
  input logic            dlv_valid,
  input logic [ID_W-1:0] dlv_agent,
  input logic [2:0]      dlv_mode,
  input logic            dlv_sync
);
  // R1
  absent_agent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dlv_valid |-> (int'(dlv_agent) < N_AGENTS));

  // R6
  lowest_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dlv_valid && dlv_mode == MODE_LOWEST) |=> !dlv_valid);

  // R7
  ascending_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dlv_valid && $past(dlv_valid)) |-> (dlv_agent > $past(dlv_agent)));

  // R8
  sync_only_init_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dlv_valid && dlv_sync) |-> (dlv_mode == MODE_INIT));

  // R9
  event_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dlv_valid |-> $past(cmd_busy));

  // R9
  dropped_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_busy && !mode_known(cmd_mode)) |=> !cmd_busy);
endmodule

bind irq_route irq_route_chk #(.N_AGENTS(N_AGENTS), .ID_W(ID_W)) chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_valid (cmd_valid),
  .cmd_mode  (cmd_mode),
  .cmd_busy  (cmd_busy),
  .dlv_valid (dlv_valid),
  .dlv_agent (dlv_agent),
  .dlv_mode  (dlv_mode),
  .dlv_sync  (dlv_sync)
);

// File: tb/irq_route_test.sv
module irq_route_test;
  localparam int N = 255;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cfg_we;
  logic [7:0] cfg_agent, cfg_logical_id, agent_count;
  logic [3:0] cfg_format;
  logic       cmd_valid, cmd_logical, cmd_trig, cmd_level;
  logic [7:0] cmd_dest, cmd_vector, cmd_src;
  logic [1:0] cmd_shorthand;
  logic [2:0] cmd_mode;
  logic       cmd_busy, dlv_valid, dlv_trig, dlv_sync;
  logic [7:0] dlv_agent, dlv_vector;
  logic [2:0] dlv_mode;

  irq_route uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_agent(cfg_agent),
    .cfg_logical_id(cfg_logical_id), .cfg_format(cfg_format),
    .agent_count(agent_count), .cmd_valid(cmd_valid), .cmd_dest(cmd_dest),
    .cmd_logical(cmd_logical), .cmd_shorthand(cmd_shorthand),
    .cmd_mode(cmd_mode), .cmd_vector(cmd_vector), .cmd_trig(cmd_trig),
    .cmd_level(cmd_level), .cmd_src(cmd_src), .cmd_busy(cmd_busy),
    .dlv_valid(dlv_valid), .dlv_agent(dlv_agent), .dlv_mode(dlv_mode),
    .dlv_vector(dlv_vector), .dlv_trig(dlv_trig), .dlv_sync(dlv_sync)
  );

  always #5 clk = ~clk;

  typedef struct {
    int agent; int mode; int vec; int trig; int sync;
  } ev_t;

  ev_t   pend[$];
  ev_t   e_cur;
  bit    e_valid = 0;
  int    m_log [N];
  int    m_fmt [N];
  int    checks = 0;
  int    fails = 0;
  int    phase_events = 0;
  string cur_req = "R10";
  bit    done = 0;

  function automatic bit model_hit(int i);
    int d;
    d = int'(cmd_dest);
    case (cmd_shorthand)
      2'd1: return i == int'(cmd_src);
      2'd2: return 1;
      2'd3: return i != int'(cmd_src);
      default: begin
        if (!cmd_logical) return (d == 255) || (d == i);
        if (m_fmt[i] == 15) return (d & m_log[i]) != 0;
        if (m_fmt[i] == 0)
          return ((d >> 4) == (m_log[i] >> 4)) && ((d & m_log[i] & 15) != 0);
        return 0;
      end
    endcase
  endfunction

  task automatic model_capture();
    ev_t e;
    int  m;
    m = int'(cmd_mode);
    if (!(m == 0 || m == 1 || m == 5 || m == 6)) return;
    for (int i = 0; i < N; i++) begin
      if (i < int'(agent_count) && model_hit(i)) begin
        e.agent = i; e.mode = m; e.vec = int'(cmd_vector);
        e.trig = int'(cmd_trig);
        e.sync = (m == 5 && !cmd_level && cmd_trig) ? 1 : 0;
        pend.push_back(e);
        if (m == 1) break;
      end
    end
  endtask

  // reference model and per-cycle comparison
  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit mis;
      bit acc;
      checks++;
      mis = (dlv_valid !== e_valid) || (cmd_busy !== (pend.size() != 0));
      if (e_valid && dlv_valid === 1'b1)
        mis = mis || (int'(dlv_agent) != e_cur.agent) || (int'(dlv_mode) != e_cur.mode) ||
              (int'(dlv_vector) != e_cur.vec) || (int'(dlv_trig) != e_cur.trig) ||
              (int'(dlv_sync) != e_cur.sync);
      if (mis) begin
        fails++;
        $display("FAIL %s: got valid=%0b agent=%0d mode=%0d vec=%0h trig=%0b sync=%0b busy=%0b expected valid=%0b agent=%0d mode=%0d vec=%0h trig=%0d sync=%0d busy=%0b",
                 cur_req, dlv_valid, dlv_agent, dlv_mode, dlv_vector, dlv_trig, dlv_sync,
                 cmd_busy, e_valid, e_cur.agent, e_cur.mode, e_cur.vec, e_cur.trig,
                 e_cur.sync, pend.size() != 0);
      end
      if (dlv_valid === 1'b1) phase_events++;
      acc = cmd_valid && (pend.size() == 0);
      if (pend.size() > 0) begin
        e_cur = pend.pop_front();
        e_valid = 1;
      end else begin
        e_valid = 0;
      end
      if (acc) model_capture();
      if (cfg_we) begin
        m_log[int'(cfg_agent)] = int'(cfg_logical_id);
        m_fmt[int'(cfg_agent)] = int'(cfg_format);
      end
    end
  end

  task automatic settle();
    do @(negedge clk); while (cmd_busy || dlv_valid || pend.size() != 0);
    repeat (2) @(negedge clk);
  endtask

  task automatic start_phase(string tag);
    settle();
    cur_req = tag;
    phase_events = 0;
  endtask

  task automatic expect_events(int n);
    settle();
    checks++;
    if (phase_events != n) begin
      fails++;
      $display("FAIL %s: event count %0d expected %0d", cur_req, phase_events, n);
    end
  endtask

  task automatic write_cfg(int a, int lid, int fmt);
    @(posedge clk); #2;
    cfg_we = 1; cfg_agent = 8'(a); cfg_logical_id = 8'(lid); cfg_format = 4'(fmt);
    @(posedge clk); #2;
    cfg_we = 0;
  endtask

  task automatic send(bit lg, int dest, int sh, int mode, int vec, bit trig, bit lvl, int src);
    @(posedge clk); #2;
    cmd_valid = 1; cmd_logical = lg; cmd_dest = 8'(dest); cmd_shorthand = 2'(sh);
    cmd_mode = 3'(mode); cmd_vector = 8'(vec); cmd_trig = trig; cmd_level = lvl;
    cmd_src = 8'(src);
    do @(negedge clk); while (cmd_busy);
    @(posedge clk); #2;
    cmd_valid = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not end, expected completion");
    finish_run();
  end

  initial begin
    for (int i = 0; i < N; i++) begin m_log[i] = 0; m_fmt[i] = 15; end
    rst_n = 0; cfg_we = 0; cfg_agent = 0; cfg_logical_id = 0; cfg_format = 0;
    agent_count = 8'd20; cmd_valid = 0; cmd_dest = 0; cmd_logical = 0;
    cmd_shorthand = 0; cmd_mode = 0; cmd_vector = 0; cmd_trig = 0; cmd_level = 0;
    cmd_src = 0;
    repeat (3) @(posedge clk); #2;
    rst_n = 1;
    @(negedge clk);
    checks++;  // R10 reset state
    if (cmd_busy !== 1'b0 || dlv_valid !== 1'b0) begin
      fails++;
      $display("FAIL R10: busy=%0b valid=%0b expected 0 0", cmd_busy, dlv_valid);
    end

    // R10: reset logical bytes are zero, so a logical broadcast reaches nobody
    start_phase("R10");
    send(1, 8'hFF, 0, 0, 8'h40, 0, 1, 0);
    expect_events(0);

    write_cfg(2, 8'h03, 15);
    write_cfg(3, 8'h01, 15);
    write_cfg(5, 8'h10, 15);
    write_cfg(7, 8'h21, 0);
    write_cfg(9, 8'h24, 0);
    write_cfg(11, 8'h31, 0);
    write_cfg(12, 8'hFF, 5);

    start_phase("R2");
    send(0, 7, 0, 0, 8'h51, 1, 1, 0);
    expect_events(1);
    start_phase("R2");
    send(0, 8'hFF, 0, 0, 8'h52, 0, 1, 0);
    expect_events(20);
    start_phase("R1");
    send(0, 30, 0, 0, 8'h53, 0, 1, 0);
    expect_events(0);

    start_phase("R3");
    send(1, 8'h11, 0, 0, 8'h60, 0, 1, 0);
    expect_events(3);
    start_phase("R4");
    send(1, 8'h25, 0, 0, 8'h61, 1, 1, 0);
    expect_events(4);
    start_phase("R4");
    send(1, 8'h22, 0, 0, 8'h62, 0, 1, 0);
    expect_events(1);

    start_phase("R5");
    send(0, 0, 1, 0, 8'h70, 0, 1, 4);
    expect_events(1);
    start_phase("R5");
    send(0, 0, 2, 0, 8'h71, 0, 1, 4);
    expect_events(20);
    start_phase("R5");
    send(0, 0, 3, 0, 8'h72, 0, 1, 4);
    expect_events(19);
    start_phase("R5");
    send(0, 0, 3, 0, 8'h73, 0, 1, 25);
    expect_events(20);

    start_phase("R6");
    send(1, 8'h25, 0, 1, 8'h80, 0, 1, 0);
    expect_events(1);
    start_phase("R6");
    send(0, 0, 2, 1, 8'h81, 1, 1, 0);
    expect_events(1);

    start_phase("R7");
    send(0, 8'hFF, 0, 5, 8'h00, 0, 1, 0);
    expect_events(20);
    start_phase("R7");
    send(0, 0, 3, 6, 8'h9A, 0, 1, 0);
    expect_events(19);

    start_phase("R8");
    send(0, 0, 2, 5, 8'h00, 1, 0, 0);
    expect_events(20);

    start_phase("R9");
    send(0, 0, 2, 2, 8'hA0, 0, 1, 0);
    send(0, 0, 2, 7, 8'hA1, 0, 1, 0);
    expect_events(0);
    start_phase("R9");
    send(0, 0, 2, 0, 8'hA2, 0, 1, 0);
    send(0, 7, 0, 0, 8'hA3, 1, 1, 0);
    send(0, 0, 1, 1, 8'hA4, 0, 1, 9);
    expect_events(22);

    start_phase("R1");
    agent_count = 8'd255;
    send(0, 8'hFF, 0, 0, 8'hB0, 0, 1, 0);
    expect_events(255);
    start_phase("R1");
    send(0, 0, 3, 0, 8'hB1, 0, 1, 254);
    expect_events(254);
    agent_count = 8'd20;

    // R11: write lands on the capture edge; old contents still apply
    start_phase("R11");
    @(posedge clk); #2;
    cmd_valid = 1; cmd_logical = 1; cmd_dest = 8'h01; cmd_shorthand = 0;
    cmd_mode = 0; cmd_vector = 8'hC0; cmd_trig = 0; cmd_level = 1; cmd_src = 0;
    cfg_we = 1; cfg_agent = 8'd3; cfg_logical_id = 8'h00; cfg_format = 4'hF;
    @(posedge clk); #2;
    cmd_valid = 0; cfg_we = 0;
    expect_events(2);
    start_phase("R11");
    send(1, 8'h01, 0, 0, 8'hC1, 0, 1, 0);
    expect_events(1);

    settle();
    finish_run();
  end
endmodule